// File: doc/BRIEF.md
# Level/Edge Digital Input Conditioner

This block conditions one external logic signal (a reset line, a power-good flag, a fault flag or a manual reset button) before it reaches a sequencing controller. The raw pin first passes through a two-flop synchroniser. In level mode the conditioned output follows the synchronised input. In edge mode a chosen transition of the synchronised input starts a pulse. The pulse length is set in microseconds, from 0 to 100.

A second, independent path combines a vector of warning flags from secondary supply detectors into one warning request for the same controller. That request is high when any flag is high.

The pulse length is counted in clock cycles. The parameter `CLK_PER_US` gives the number of clock cycles per microsecond.

Top module: `dig_in_cond`

## Requirements
- R1: After a synchronous active-low reset, `cond_out` is 0 while `pin_in` stays 0, and no pulse is pending.
- R2: With `mode_edge` = 0, `cond_out` equals `pin_in` as it was sampled two rising clock edges earlier.
- R3: `edge_sel` picks the trigger edge: 2'b00 = rising only, 2'b01 = falling only, 2'b10 and 2'b11 = either. A transition that is not selected produces no pulse.
- R4: With `mode_edge` = 1, suppose a selected transition of `pin_in` is first sampled at clock edge k. Then `cond_out` is high from clock edge k+2 for exactly W × `CLK_PER_US` cycles, where W is the width setting.
- R5: A width setting of 0 produces no pulse in edge mode.
- R6: A width setting above `MAX_US` (default 100) acts as `MAX_US`.
- R7: A selected transition that arrives while a pulse is active restarts the full width count from that transition's own load cycle.
- R8: The width is captured when the pulse starts. A later change of `width_us` does not alter a pulse that is already running.
- R9: Setting `mode_edge` to 0 clears any pulse in progress. Returning to edge mode without a new selected transition gives `cond_out` = 0.
- R10: `warn_any` is 1 exactly when at least one bit of `warn_in` is 1. It is combinational, with no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Raw asynchronous logic input |
| mode_edge | input | 1 | 0 = level mode, 1 = edge/pulse mode |
| edge_sel | input | 2 | Trigger edge select (see R3) |
| width_us | input | $clog2(MAX_US+1) | Pulse width in microseconds |
| cond_out | output | 1 | Conditioned output |
| warn_in | input | N_WARN | Warning flags from secondary detectors |
| warn_any | output | 1 | OR of all warning flags |

## Verification
The hardest situations to create are a retrigger that lands partway through a running pulse, and a mode switch while a pulse is active. The bench builds both from the ports. It drives a second transition at a fixed cycle inside the measurement window and checks that the pulse stays unbroken and ends one full width after the second load. It also switches to level mode mid-pulse while the input is low, then returns to edge mode, and checks that no remaining pulse reappears. A sweep over every width code, including zero and the codes above the clamp, checks pulse start and length against a value the bench computes itself.

// File: rtl/dic_pkg.sv
// Shared types for the digital input conditioner.
// Assumes: the edge select is a 2-bit field whose codes are set out in the brief.
package dic_pkg;
    typedef enum logic [1:0] {
        SEL_RISE  = 2'b00,
        SEL_FALL  = 2'b01,
        SEL_BOTH  = 2'b10,
        SEL_BOTH2 = 2'b11
    } edge_sel_t;
endpackage

// File: rtl/dic_sync.sv
// Two-flop synchroniser for an asynchronous pin.
// Assumes: the pin is a slow logic level. The first flop may go metastable; the second absorbs it.
module dic_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic meta_q;

    // Shift the pin through two flops; reset drives both to 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            q_sync <= 1'b0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/dic_edge_det.sv
// Detects the selected transition(s) of an already synchronised signal.
// Assumes: sig is synchronous to clk. The hit output is combinational and lasts one cycle per transition.
module dic_edge_det
    import dic_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sig,
    input  edge_sel_t sel,
    output logic      hit
);
    logic prev_q;
    logic rise;
    logic fall;

    // Keep last cycle's value for the comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    // Classify the transition and gate it with the selection.
    always_comb begin
        rise = sig & ~prev_q;
        fall = ~sig & prev_q;
        unique case (sel)
            SEL_RISE: hit = rise;
            SEL_FALL: hit = fall;
            default:  hit = rise | fall;
        endcase
    end

    // R3: a hit is only possible when the signal actually changed.
    p_edge_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (sig != $past(sig)));
endmodule

// File: rtl/dic_pulse_gen.sv
// Retriggerable pulse generator with its length set in microseconds.
// Assumes: trig is a single-cycle strobe. The width is clamped to MAX_US, scaled by
// CLK_PER_US and latched at load time. The counter clears whenever enable is low.
module dic_pulse_gen #(
    parameter int CLK_PER_US = 250,
    parameter int MAX_US     = 100,
    localparam int WW        = $clog2(MAX_US + 1),
    localparam int MAXCNT    = MAX_US * CLK_PER_US,
    localparam int CW        = $clog2(MAXCNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          trig,
    input  logic [WW-1:0] width,
    output logic          pulse
);
    logic [WW-1:0] width_eff;
    logic [CW-1:0] load_val;
    logic [CW-1:0] cnt_q;

    // Clamp the width code and convert it to clock cycles.
    always_comb begin
        width_eff = (int'(width) > MAX_US) ? WW'(MAX_US) : width;
        load_val  = CW'(width_eff) * CW'(CLK_PER_US);
    end

    // Load on trigger, count down while active, clear when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) cnt_q <= '0;
        else if (trig)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign pulse = (cnt_q != '0);

    // R4: an active pulse with no retrigger shortens by exactly one cycle.
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !trig && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R5: a zero-width trigger leaves no pulse.
    p_zero_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && trig && width == '0) |=> (cnt_q == '0));
    // R6: the counter never exceeds the clamped maximum.
    p_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= MAXCNT);
    // R9: a disabled generator holds no pulse.
    p_level_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt_q == '0));
endmodule

// File: rtl/dic_warn_or.sv
// Combines a vector of warning flags into one request through an OR chain.
// Assumes: the flags are already synchronous; no registering is added.
module dic_warn_or #(
    parameter int N_WARN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_WARN-1:0] flags,
    output logic              any
);
    logic [N_WARN:0] acc;

    assign acc[0] = 1'b0;
    for (genvar i = 0; i < N_WARN; i++) begin : g_chain
        assign acc[i+1] = acc[i] | flags[i];
    end
    assign any = acc[N_WARN];

    // R10: a quiet vector gives no request, and any set bit gives one.
    p_warn_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> !any);
    p_warn_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(flags) > 0) |-> any);
endmodule

// File: rtl/dig_in_cond.sv
// Top of the digital input conditioner: synchroniser, edge detector, pulse generator
// and warning combiner.
// Assumes: mode_edge, edge_sel and width_us are static or change synchronously to clk.
// The output mux is combinational on mode_edge.
module dig_in_cond
    import dic_pkg::*;
#(
    parameter int CLK_PER_US = 250,
    parameter int MAX_US     = 100,
    parameter int N_WARN     = 5,
    localparam int WW        = $clog2(MAX_US + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_in,
    input  logic              mode_edge,
    input  logic [1:0]        edge_sel,
    input  logic [WW-1:0]     width_us,
    output logic              cond_out,
    input  logic [N_WARN-1:0] warn_in,
    output logic              warn_any
);
    logic      sync_q;
    logic      hit;
    logic      pulse;
    edge_sel_t sel;
    logic [1:0] age_q;

    assign sel = edge_sel_t'(edge_sel);

    dic_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (sync_q)
    );

    dic_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (sync_q),
        .sel   (sel),
        .hit   (hit)
    );

    dic_pulse_gen #(
        .CLK_PER_US (CLK_PER_US),
        .MAX_US     (MAX_US)
    ) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (mode_edge),
        .trig   (hit),
        .width  (width_us),
        .pulse  (pulse)
    );

    dic_warn_or #(.N_WARN(N_WARN)) u_warn (
        .clk   (clk),
        .rst_n (rst_n),
        .flags (warn_in),
        .any   (warn_any)
    );

    // Select the level copy or the pulse as the conditioned output.
    assign cond_out = mode_edge ? pulse : sync_q;

    // Count cycles since reset (saturating) so the latency check has history.
    always_ff @(posedge clk) begin
        if (!rst_n)            age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R2: in level mode the output is the pin delayed by two clocks.
    p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && !mode_edge) |-> (cond_out == $past(pin_in, 2)));
endmodule

// File: tb/dig_in_cond_bench.sv
module dig_in_cond_bench;
    localparam int TPU  = 2;
    localparam int MAXU = 100;
    localparam int NW   = 4;
    localparam int WW   = $clog2(MAXU + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pin_in = 1'b0;
    logic          mode_edge = 1'b0;
    logic [1:0]    edge_sel = 2'b00;
    logic [WW-1:0] width_us = '0;
    logic          cond_out;
    logic [NW-1:0] warn_in = '0;
    logic          warn_any;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dig_in_cond #(.CLK_PER_US(TPU), .MAX_US(MAXU), .N_WARN(NW)) u_dig_in_cond (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .mode_edge(mode_edge),
        .edge_sel(edge_sel), .width_us(width_us), .cond_out(cond_out),
        .warn_in(warn_in), .warn_any(warn_any)
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts the high cycles of cond_out over lim negedges and records the first high index.
    task automatic measure(input int lim, output int first, output int len);
        first = -1;
        len = 0;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (cond_out) begin
                if (first < 0) first = i;
                len++;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int first, len, expl;
        logic [7:0] lfsr;
        logic [1:0] hist;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 cond_out after reset", int'(cond_out), 0);
        chk("R1 warn_any after reset", int'(warn_any), 0);

        // R2: level mode follows the pin two clocks later
        lfsr = 8'h5a;
        hist = 2'b00;
        pin_in = 1'b0;
        idle(3);
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            if (n >= 2) chk("R2 level copy", int'(cond_out), int'(hist[1]));
            hist = {hist[0], lfsr[0]};
            pin_in = lfsr[0];
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end

        // R3: edge select codes against both transition directions
        width_us = WW'(5);
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 2; d++) begin
                bit qual;
                mode_edge = 1'b0;
                edge_sel = 2'(s);
                pin_in = (d == 0) ? 1'b0 : 1'b1;
                idle(4);
                mode_edge = 1'b1;
                idle(2);
                pin_in = ~pin_in;
                measure(20, first, len);
                qual = (s >= 2) || (s == 0 && d == 0) || (s == 1 && d == 1);
                chk("R3 pulse length per select", len, qual ? 5 * TPU : 0);
                if (qual) chk("R3 pulse start", first, 3);
            end
        end

        // R4 R5 R6: every width code, with either edge
        mode_edge = 1'b1;
        edge_sel = 2'b10;
        for (int w = 0; w < (1 << WW); w++) begin
            width_us = WW'(w);
            pin_in = ~pin_in;
            measure(MAXU * TPU + 10, first, len);
            expl = ((w > MAXU) ? MAXU : w) * TPU;
            if (w == 0) chk("R5 zero width no pulse", len, 0);
            else if (w > MAXU) chk("R6 clamped width", len, expl);
            else chk("R4 pulse length", len, expl);
            if (expl > 0) chk("R4 pulse start", first, 3);
        end

        // R7: retrigger inside a running pulse
        width_us = WW'(10);
        pin_in = ~pin_in;
        first = -1;
        len = 0;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (cond_out) begin
                if (first < 0) first = i;
                len++;
            end
            if (i == 8) pin_in = ~pin_in;
        end
        chk("R7 retrigger total length", len, 8 + 10 * TPU);
        chk("R7 retrigger start", first, 3);

        // R8: width change during a pulse has no effect
        width_us = WW'(10);
        pin_in = ~pin_in;
        len = 0;
        for (int i = 1; i <= 150; i++) begin
            @(negedge clk);
            if (cond_out) len++;
            if (i == 5) width_us = WW'(50);
        end
        chk("R8 width latched at start", len, 10 * TPU);

        // R9: leaving edge mode aborts the pulse
        mode_edge = 1'b0;
        edge_sel = 2'b01;
        width_us = WW'(20);
        pin_in = 1'b1;
        idle(4);
        mode_edge = 1'b1;
        idle(2);
        pin_in = 1'b0;
        idle(6);
        chk("R9 pulse running before abort", int'(cond_out), 1);
        mode_edge = 1'b0;
        idle(2);
        mode_edge = 1'b1;
        measure(50, first, len);
        chk("R9 no pulse after mode return", len, 0);

        // R10: every warning vector
        for (int v = 0; v < (1 << NW); v++) begin
            warn_in = NW'(v);
            #1;
            chk("R10 warning OR", int'(warn_any), (v != 0) ? 1 : 0);
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule